// File: doc/BRIEF.md
# High-Resolution PWM Generator with Coarse and Fine Timing

This block produces a fixed-rate pulse-width modulated output from a 16-bit duty word. Its default configuration runs a 100 kHz period from a 100 MHz system clock. The upper ten bits of the word give the pulse width in whole system-clock cycles, and a counter on that clock times them. The lower six bits form a phase code. The block hands this code to an external fine-delay stage, which places the trailing edge between clock edges.

Each period, the start of the count drives the output high. Near the end of the programmed coarse width, the block raises a one-cycle arm pulse toward the fine-delay stage. The stage sends the pulse back delayed by the selected phase. The block brings that returned edge into its clock domain and uses it to drive the output low, which gives set/reset behaviour. An inverted copy of the output is also provided.

A two-entry queue feeds the duty words. The block takes one word at each falling edge of the pulse, so the next phase code settles well before the following pulse. Every word is clamped to a 10 %–90 % window. When the queue is empty at a load point, the block keeps the current word and raises a sticky underrun flag.

Top module: `hires_pwm`

## Requirements
- R1: Rising edges of `pwm_out` are spaced exactly PERIOD_CYC system-clock cycles apart (1000 by default).
- R2: Within a period, `pwm_out` stays high for exactly W cycles. W is bits 15:6 of the duty word applied in that period.
- R3: For the whole high phase of a period, `phase_code` equals bits 5:0 of the duty word applied in that period.
- R4: A written word below MIN_WORD = (PERIOD_CYC·10/100)·64 is applied as MIN_WORD. A word above MAX_WORD = (PERIOD_CYC·90/100)·64 is applied as MAX_WORD. Any coarse field at or above the period length therefore saturates.
- R5: The block consumes one queued word per period, at the falling edge of the pulse. The k-th word written after reset (k counted from 1) governs period k, and period 0 uses the reset default.
- R6: The queue holds two words. `duty_ready` is low while both entries are occupied.
- R7: If the queue is empty at a falling edge, the block keeps applying the previous word. `underrun` then goes high and stays high until reset.
- R8: `pwm_out_n` is always the complement of `pwm_out`.
- R9: During reset, `pwm_out` is low, `underrun` is low, the queue is empty (`duty_ready` high), and the applied word is MIN_WORD (`phase_code` = 0). The first period after reset has width MIN_WORD/64.
- R10: `fine_arm` pulses for exactly one cycle per period. It falls on high-phase cycle W−2, counting the first high cycle as 1. The last high cycle comes two cycles after the arm pulse, because the returned edge passes through two synchronizing stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| duty_wdata | input | 16 | Duty word to queue: bits 15:6 coarse cycles, bits 5:0 phase code |
| duty_wvalid | input | 1 | Write strobe for `duty_wdata`, taken when `duty_ready` is high |
| duty_ready | output | 1 | Queue has a free entry |
| phase_code | output | 6 | Phase select for the external fine-delay stage |
| fine_arm | output | 1 | One-cycle pulse sent into the fine-delay stage |
| fine_edge | input | 1 | Delayed arm pulse returned from the fine-delay stage, asynchronous |
| pwm_out | output | 1 | PWM output |
| pwm_out_n | output | 1 | Inverted PWM output |
| underrun | output | 1 | Sticky: a load point found the queue empty |

## Verification
Every result is due a fixed number of cycles after its cause:
- The output rises one cycle after the count wraps.
- The arm pulse rises on high-phase cycle W−2.
- The output falls two cycles after the arm pulse, so the last high cycle is W.
- A word popped at a falling edge shows up on `phase_code` on the next cycle and governs the following period.
- The underrun flag rises one cycle after an empty load point.

The bench samples at falling clock edges. It counts high cycles, total cycles and the arm position for each period, then compares them with widths computed arithmetically from the clamped word schedule. The underrun state is checked at each period start, so it has always settled by the time it is checked.

// File: rtl/hires_pwm_pkg.sv
package hires_pwm_pkg;
  // number of flops the returned fine edge passes before it can clear the output
  localparam int unsigned SYNC_LAT = 2;
  // cycles between the registered arm compare and the arm pulse itself
  localparam int unsigned ARM_REG_LAT = 1;
endpackage

// File: rtl/pwm_duty_fifo.sv
module pwm_duty_fifo #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty,
  output logic             full
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] PLAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] CFULL = CW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] count_q, count_d;
  logic push, pop;

  assign empty   = (count_q == '0);
  assign full    = (count_q == CFULL);
  assign push    = wr_en && !full;
  assign pop     = rd_en && !empty;
  assign rd_data = mem[rd_ptr_q];

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    count_d  = count_q;
    if (push) wr_ptr_d = (wr_ptr_q == PLAST) ? '0 : wr_ptr_q + 1'b1;
    if (pop)  rd_ptr_d = (rd_ptr_q == PLAST) ? '0 : rd_ptr_q + 1'b1;
    case ({push, pop})
      2'b10:   count_d = count_q + 1'b1;
      2'b01:   count_d = count_q - 1'b1;
      default: count_d = count_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      count_q  <= count_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr_q] <= wr_data;
  end

  // R6: occupancy never exceeds the queue depth
  p_depth_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CFULL);
  // R6: a write into a full queue without a read leaves it full
  p_full_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en && !rd_en) |=> (count_q == CFULL));
endmodule

// File: rtl/pwm_duty_clamp.sv
module pwm_duty_clamp #(
  parameter int unsigned WIDTH    = 16,
  parameter int unsigned MIN_WORD = 6400,
  parameter int unsigned MAX_WORD = 57600
) (
  input  logic [WIDTH-1:0] raw,
  output logic [WIDTH-1:0] bounded
);
  localparam logic [WIDTH-1:0] LO = WIDTH'(MIN_WORD);
  localparam logic [WIDTH-1:0] HI = WIDTH'(MAX_WORD);

  always_comb begin
    if (raw < LO)      bounded = LO;
    else if (raw > HI) bounded = HI;
    else               bounded = raw;
  end
endmodule

// File: rtl/pwm_edge_sync.sv
module pwm_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES:0] sh_q, sh_d;

  always_comb sh_d = {sh_q[STAGES-1:0], async_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise = sh_q[STAGES-1] && !sh_q[STAGES];
endmodule

// File: rtl/pwm_period_timer.sv
module pwm_period_timer #(
  parameter int unsigned PERIOD_CYC = 1000,
  parameter int unsigned CNT_W      = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt,
  output logic             start
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_CYC - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt   = cnt_q;
  assign start = (cnt_q == '0);

  // R1: the count wraps to zero right after the last cycle of a period
  p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == LAST) |=> (cnt_q == '0));
endmodule

// File: rtl/hires_pwm.sv
module hires_pwm #(
  parameter int unsigned PERIOD_CYC = 1000,
  parameter int unsigned COARSE_W   = 10,
  parameter int unsigned FINE_W     = 6,
  parameter int unsigned FIFO_DEPTH = 2,
  parameter int unsigned MIN_PCT    = 10,
  parameter int unsigned MAX_PCT    = 90
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [COARSE_W+FINE_W-1:0] duty_wdata,
  input  logic                       duty_wvalid,
  output logic                       duty_ready,
  output logic [FINE_W-1:0]          phase_code,
  output logic                       fine_arm,
  input  logic                       fine_edge,
  output logic                       pwm_out,
  output logic                       pwm_out_n,
  output logic                       underrun
);
  import hires_pwm_pkg::*;

  localparam int unsigned DUTY_W     = COARSE_W + FINE_W;
  localparam int unsigned MIN_COARSE = PERIOD_CYC * MIN_PCT / 100;
  localparam int unsigned MAX_COARSE = PERIOD_CYC * MAX_PCT / 100;
  localparam int unsigned MIN_WORD   = MIN_COARSE << FINE_W;
  localparam int unsigned MAX_WORD   = MAX_COARSE << FINE_W;
  localparam logic [DUTY_W-1:0]   DEF_WORD = DUTY_W'(MIN_WORD);
  localparam logic [COARSE_W-1:0] ARM_OFS  = COARSE_W'(SYNC_LAT + ARM_REG_LAT);

  // reset: asynchronous assertion, synchronous release
  logic rst_meta_q, rst_sync_q, rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end
  assign rst_i = rst_sync_q;

  // period timing
  logic [COARSE_W-1:0] cnt;
  logic                start;
  pwm_period_timer #(.PERIOD_CYC(PERIOD_CYC), .CNT_W(COARSE_W)) u_timer (
    .clk(clk), .rst_n(rst_i), .cnt(cnt), .start(start)
  );

  // duty queue and clamp
  logic [DUTY_W-1:0] fifo_rdata, clamped;
  logic fifo_empty, fifo_full, fifo_pop;
  pwm_duty_fifo #(.WIDTH(DUTY_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_i), .wr_en(duty_wvalid), .wr_data(duty_wdata),
    .rd_en(fifo_pop), .rd_data(fifo_rdata), .empty(fifo_empty), .full(fifo_full)
  );
  pwm_duty_clamp #(.WIDTH(DUTY_W), .MIN_WORD(MIN_WORD), .MAX_WORD(MAX_WORD)) u_clamp (
    .raw(fifo_rdata), .bounded(clamped)
  );

  // returned fine edge
  logic edge_rise;
  pwm_edge_sync #(.STAGES(SYNC_LAT)) u_sync (
    .clk(clk), .rst_n(rst_i), .async_in(fine_edge), .rise(edge_rise)
  );

  // output state
  logic [DUTY_W-1:0]   duty_q, duty_d;
  logic [COARSE_W-1:0] coarse;
  logic pwm_q, pwm_d, arm_q, arm_d, under_q, under_d, fall_evt;

  assign coarse   = duty_q[DUTY_W-1:FINE_W];
  assign fall_evt = edge_rise && pwm_q;
  assign fifo_pop = fall_evt;

  always_comb begin
    pwm_d   = pwm_q;
    duty_d  = duty_q;
    under_d = under_q;
    arm_d   = pwm_q && (cnt == coarse - ARM_OFS);
    if (start)         pwm_d = 1'b1;
    else if (fall_evt) pwm_d = 1'b0;
    if (fall_evt) begin
      if (!fifo_empty) duty_d  = clamped;
      else             under_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      pwm_q   <= 1'b0;
      arm_q   <= 1'b0;
      under_q <= 1'b0;
      duty_q  <= DEF_WORD;
    end else begin
      pwm_q   <= pwm_d;
      arm_q   <= arm_d;
      under_q <= under_d;
      duty_q  <= duty_d;
    end
  end

  assign pwm_out    = pwm_q;
  assign pwm_out_n  = ~pwm_q;
  assign fine_arm   = arm_q;
  assign phase_code = duty_q[FINE_W-1:0];
  assign underrun   = under_q;
  assign duty_ready = !fifo_full;

  // R1: the start of a period drives the output high
  p_start_sets_r1: assert property (@(posedge clk) disable iff (!rst_i)
    start |=> pwm_q);
  // R10: the arm pulse lasts exactly one cycle
  p_arm_pulse_r10: assert property (@(posedge clk) disable iff (!rst_i)
    arm_q |=> !arm_q);
  // R10: the arm pulse only occurs during the high phase
  p_arm_in_high_r10: assert property (@(posedge clk) disable iff (!rst_i)
    arm_q |-> pwm_q);
  // R4: the applied word stays inside the clamp window
  p_word_range_r4: assert property (@(posedge clk) disable iff (!rst_i)
    (duty_q >= DUTY_W'(MIN_WORD)) && (duty_q <= DUTY_W'(MAX_WORD)));
  // R7: an empty load point keeps the applied word
  p_hold_on_empty_r7: assert property (@(posedge clk) disable iff (!rst_i)
    (fall_evt && fifo_empty) |=> $stable(duty_q));
  // R7: the underrun flag is sticky
  p_underrun_sticky_r7: assert property (@(posedge clk) disable iff (!rst_i)
    under_q |=> under_q);
endmodule

// File: tb/test_hires_pwm.sv
module test_hires_pwm;
  localparam int P        = 200;
  localparam int CLK_T    = 640;
  localparam int FW       = 6;
  localparam int MINW     = (P * 10 / 100) * 64;
  localparam int MAXW     = (P * 90 / 100) * 64;
  localparam int NV       = 70;
  localparam int WDOG_CYC = 100000;

  logic clk = 1'b0;
  logic rst_n;
  logic [15:0] duty_wdata;
  logic duty_wvalid;
  logic duty_ready;
  logic [5:0] phase_code;
  logic fine_arm;
  logic fine_edge = 1'b0;
  logic pwm_out, pwm_out_n, underrun;

  int total = 0;
  int bad   = 0;

  always #(CLK_T/2) clk = ~clk;

  hires_pwm #(.PERIOD_CYC(P)) i_hires_pwm (
    .clk(clk), .rst_n(rst_n), .duty_wdata(duty_wdata), .duty_wvalid(duty_wvalid),
    .duty_ready(duty_ready), .phase_code(phase_code), .fine_arm(fine_arm),
    .fine_edge(fine_edge), .pwm_out(pwm_out), .pwm_out_n(pwm_out_n),
    .underrun(underrun)
  );

  // fine-delay stage model: tapped delay of (code + 1/2) steps of T/64
  always @(fine_arm) fine_edge <= #(int'(phase_code) * (CLK_T / 64) + (CLK_T / 128)) fine_arm;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int vec(input int i);
    case (i)
      0: return 0;
      1: return 16'hFFFF;
      2: return MINW - 1;
      3: return MINW;
      4: return MAXW;
      5: return MAXW + 1;
      6: return (P << FW) | 7;
      default: return (((i * 13) % P) << FW) | ((i * 37) % 64);
    endcase
  endfunction

  function automatic int clampw(input int w);
    if (w < MINW) return MINW;
    if (w > MAXW) return MAXW;
    return w;
  endfunction

  function automatic int exp_word(input int p);
    if (p == 0) return MINW;
    if (p - 1 < NV) return clampw(vec(p - 1));
    return clampw(vec(NV - 1));
  endfunction

  // measures one period starting at the first high cycle
  task automatic run_period(input int p);
    int hi = 0, tot = 0, arms = 0, armpos = -1, badfc = -1, badinv = 0;
    int ew = exp_word(p);
    int ec = ew >> FW;
    int ef = ew % 64;
    int raw = (p >= 1 && p - 1 < NV) ? vec(p - 1) : ew;
    chk(underrun == (p > NV), "R7 underrun at period start", int'(underrun), int'(p > NV));
    while (pwm_out) begin
      hi++;
      if (fine_arm) begin arms++; armpos = hi; end
      if (int'(phase_code) != ef) badfc = int'(phase_code);
      if (pwm_out_n !== ~pwm_out) badinv++;
      @(negedge clk);
    end
    tot = hi;
    while (!pwm_out) begin
      tot++;
      if (pwm_out_n !== ~pwm_out) badinv++;
      @(negedge clk);
    end
    if (raw != ew) chk(hi == ec, "R4 clamped width", hi, ec);
    else           chk(hi == ec, "R2 width", hi, ec);
    chk(badfc < 0, "R3 phase code", badfc, ef);
    chk(tot == P, "R1 period", tot, P);
    chk(arms == 1 && armpos == ec - 2, "R10 arm position", armpos, ec - 2);
    chk(badinv == 0, "R8 inverted output", badinv, 0);
    if (p >= 1 && p <= NV) chk(hi == ec && badfc < 0, "R5 queue order", hi, ec);
  endtask

  task automatic reset_checks();
    chk(pwm_out == 1'b0, "R9 pwm low in reset", int'(pwm_out), 0);
    chk(pwm_out_n == 1'b1, "R9 inverted high in reset", int'(pwm_out_n), 1);
    chk(underrun == 1'b0, "R9 underrun clear", int'(underrun), 0);
    chk(duty_ready == 1'b1, "R9 queue empty", int'(duty_ready), 1);
    chk(phase_code == 6'd0, "R9 default phase", int'(phase_code), 0);
  endtask

  // duty word driver
  initial begin
    @(posedge rst_n);
    repeat (4) @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      while (!duty_ready) @(negedge clk);
      duty_wdata  = 16'(vec(i));
      duty_wvalid = 1'b1;
      @(negedge clk);
      duty_wvalid = 1'b0;
      if (i == 1) chk(duty_ready == 1'b0, "R6 ready low when full", int'(duty_ready), 0);
    end
  end

  // watchdog
  initial begin
    repeat (WDOG_CYC) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n       = 1'b0;
    duty_wvalid = 1'b0;
    duty_wdata  = '0;
    repeat (3) @(negedge clk);
    reset_checks();
    rst_n = 1'b1;
    do @(negedge clk); while (!pwm_out);
    for (int p = 0; p < NV + 3; p++) run_period(p);
    // second reset mid-period: default word returns, queue and flag clear
    repeat (30) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    reset_checks();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    do @(negedge clk); while (!pwm_out);
    run_period(0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule